// File: doc/BRIEF.md
# Byte Transmit Queue with Depth-Revealing Threshold

This block is the transmit-side byte queue of a serial controller. Software pushes bytes by writing a data offset on a simple register port. The serial engine drains them from the other side through a pop strobe. The oldest byte is always presented on `pop_data`, with no read latency. The queue reports empty, full and its fill level. It also raises a low-water flag whenever the fill level is strictly below a programmable threshold. The engine's interrupt logic uses that flag to ask for more data.

The threshold register holds only enough bits to store `DEPTH-1`. Bits above that width are discarded on a write. Software can therefore find the queue depth at run time: it writes all ones and reads the register back, which yields `DEPTH-1`. The threshold comes out of reset at 1.

A control state machine tracks occupancy in three states: `Q_EMPTY`, `Q_PART` (partly filled) and `Q_FULL`. Its transitions are:
- fill: `Q_EMPTY`→`Q_PART` on an accepted push.
- top-off: `Q_PART`→`Q_FULL` on a push alone at level `DEPTH-1`.
- drain: `Q_PART`→`Q_EMPTY` on a pop alone at level 1.
- release: `Q_FULL`→`Q_PART` on a pop.
- flush: any state→`Q_EMPTY` when `flush` is high.

In every other case the state holds. A push and a pop in the same cycle are treated as described in R6 and R4.

Top module: `txq_watermark_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, the threshold reads back as 1, and `below_mark`=1.
- R2: A `reg_wr` to offset 0x1C pushes `reg_wdata[7:0]` when the queue is not full. `level` rises by one after that clock edge. Bytes leave in the order they were written.
- R3: `pop_data` shows the oldest stored byte combinationally. A `pop` while not empty removes it at the clock edge.
- R4: A push while `full` is dropped. `level` and the stored bytes are unchanged. If a pop occurs in the same cycle, the pop still takes effect.
- R5: A `pop` while `empty` has no effect. `pop_data` reads 0 while empty.
- R6: A push and a pop together while in `Q_PART` leave `level` unchanged and keep byte order. Together while empty, only the push takes effect.
- R7: A `reg_wr` to offset 0x28 stores the low `log2(DEPTH)` bits of `reg_wdata` as the threshold. Writing 0xFFFF reads back 7 when `DEPTH`=8.
- R8: `below_mark` is 1 exactly when `level` < threshold. It changes in the same cycle as `level` or the threshold.
- R9: A high `flush` at a clock edge empties the queue (`level`=0, `empty`=1) and overrides a push in that cycle. The threshold is kept.
- R10: `reg_rdata` returns the zero-extended threshold when `reg_addr` is 0x28 and 0 for any other address. Writes to other addresses change nothing.
- R11: `full` is 1 exactly in `Q_FULL`, with `level`=`DEPTH`. `empty` is 1 exactly in `Q_EMPTY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous queue clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pop | input | 1 | Engine pop strobe |
| pop_data | output | 8 | Oldest byte, 0 when empty |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| level | output | 4 | Number of stored bytes |
| below_mark | output | 1 | Level strictly below threshold |

## Verification
Each write or pop is applied for one rising edge. `level`, `full`, `empty`, `below_mark` and the threshold change at that edge, so they are due one cycle after the stimulus. `pop_data` and `reg_rdata` are combinational and are due in the same cycle as their inputs. The bench changes inputs on the falling edge and samples every result on the following falling edge. Register reads are sampled a nanosecond after the address is driven.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txq_thresh.sv
module txq_thresh #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] thresh
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh <= PTR_W'(1);
        end else if (wr_en) begin
            thresh <= wdata;
        end
    end

    // R7: a write lands in the threshold on the next edge
    a_r7_thresh_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> thresh == $past(wdata));
    // R9/R10: with no write the threshold holds
    a_r10_thresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(thresh));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    q_state_e state, state_nx;
    logic     pop_ok;

    assign push_ok = push_req && !flush && (state != Q_FULL);
    assign pop_ok  = pop_req  && !flush && (state != Q_EMPTY);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // next-state logic
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = Q_EMPTY;
        end else begin
            unique case (state)
                Q_EMPTY: if (push_ok) state_nx = Q_PART;
                Q_PART: begin
                    if (push_ok && !pop_ok && level == LVL_TOP) begin
                        state_nx = Q_FULL;
                    end else if (pop_ok && !push_ok && level == LVL_ONE) begin
                        state_nx = Q_EMPTY;
                    end
                end
                Q_FULL:  if (pop_ok) state_nx = Q_PART;
                default: state_nx = Q_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // outputs
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            Q_EMPTY: empty = 1'b1;
            Q_FULL:  full  = 1'b1;
            default: ;
        endcase
    end

    a_r11_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> level == LVL_W'(DEPTH));
    a_r11_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> level == '0);
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req && !flush) |=> $stable(level) && $stable(wr_ptr));
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req && !flush) |=> $stable(level) && $stable(rd_ptr));
    a_r6_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !full && !empty && !flush) |=> $stable(level));
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && level == '0);
endmodule

// File: rtl/txq_watermark_fifo.sv
module txq_watermark_fifo #(
    parameter int DEPTH    = 8,
    parameter int DATA_W   = 8,
    parameter int REG_AW   = 8,
    parameter int REG_DW   = 16,
    parameter logic [REG_AW-1:0] DATA_OFS = 8'h1C,
    parameter logic [REG_AW-1:0] THR_OFS  = 8'h28,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [LVL_W-1:0]  level,
    output logic              below_mark
);
    logic             push_req, thr_wr, push_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr, thresh;
    logic [DATA_W-1:0] head;
    logic             unused_bits;

    assign push_req    = reg_wr && (reg_addr == DATA_OFS);
    assign thr_wr      = reg_wr && (reg_addr == THR_OFS);
    assign unused_bits = ^reg_wdata[REG_DW-1:DATA_W];

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_req(push_req), .pop_req(pop), .push_ok(push_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
        .full(full), .empty(empty)
    );

    txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(push_ok), .waddr(wr_ptr),
        .wdata(reg_wdata[DATA_W-1:0]), .raddr(rd_ptr), .rdata(head)
    );

    txq_thresh #(.DEPTH(DEPTH)) u_thresh (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_wr),
        .wdata(reg_wdata[PTR_W-1:0]), .thresh(thresh)
    );

    assign pop_data   = empty ? '0 : head;
    assign below_mark = level < {1'b0, thresh};
    assign reg_rdata  = (reg_addr == THR_OFS) ? REG_DW'(thresh) : '0;

    // R8: the flag tracks the level against the stored threshold
    a_r8_mark_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && thresh != '0) |=> below_mark);
    // R5: an empty queue presents zero
    a_r5_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> pop_data == '0);
endmodule

// File: tb/txq_watermark_fifo_test.sv
`timescale 1ns/1ps
module txq_watermark_fifo_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        flush = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        pop = 0;
    logic [7:0]  pop_data;
    logic        full, empty, below_mark;
    logic [3:0]  level;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    txq_watermark_fifo uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pop(pop), .pop_data(pop_data), .full(full), .empty(empty),
        .level(level), .below_mark(below_mark)
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; pop = 0; flush = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic do_pop();
        pop = 1;
        step();
    endtask

    task automatic rd_thr(output int v);
        reg_addr = 8'h28;
        #1 v = reg_rdata;
    endtask

    task automatic t_reset();
        int v;
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 level", level, 0);
        chk("R1 below_mark", below_mark, 1);
        rd_thr(v);
        chk("R1 threshold", v, 1);
        chk("R11 empty state", empty, 1);
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < 8; i++) begin
            wr(8'h1C, 16'hAB00 | 16'(8'hA0 + i));
            chk("R2 level rise", level, i + 1);
        end
        chk("R11 full", full, 1);
        chk("R11 not empty", empty, 0);
        wr(8'h1C, 16'h00EE);
        chk("R4 level held", level, 8);
        chk("R4 still full", full, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R3 head order", pop_data, 8'hA0 + i);
            do_pop();
        end
        chk("R2 drained", empty, 1);
    endtask

    task automatic t_underflow();
        chk("R5 zero data", pop_data, 0);
        do_pop();
        chk("R5 level", level, 0);
        chk("R5 empty", empty, 1);
        wr(8'h1C, 16'h0055);
        chk("R5 pointers intact", pop_data, 8'h55);
    endtask

    task automatic t_simul();
        wr(8'h1C, 16'h0066);
        chk("R6 level two", level, 2);
        reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 16'h0077; pop = 1;
        step();
        chk("R6 level kept", level, 2);
        chk("R6 order", pop_data, 8'h66);
        do_pop();
        chk("R6 tail", pop_data, 8'h77);
        do_pop();
        reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 16'h0031; pop = 1;
        step();
        chk("R6 empty push wins", level, 1);
        chk("R6 empty push data", pop_data, 8'h31);
        for (int i = 0; i < 7; i++) wr(8'h1C, 16'(i));
        reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 16'h00FF; pop = 1;
        step();
        chk("R4 full pop only", level, 7);
        chk("R4 full head", pop_data, 0);
    endtask

    task automatic t_thresh();
        int v;
        wr(8'h28, 16'hFFFF);
        rd_thr(v);
        chk("R7 all ones", v, 7);
        wr(8'h28, 16'h000D);
        rd_thr(v);
        chk("R7 truncation", v, 5);
        wr(8'h28, 16'h0003);
        rd_thr(v);
        chk("R7 load", v, 3);
    endtask

    task automatic t_flush_mark();
        int v;
        flush = 1; reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 16'h0099;
        step();
        chk("R9 level zero", level, 0);
        chk("R9 empty", empty, 1);
        chk("R9 data zero", pop_data, 0);
        rd_thr(v);
        chk("R9 threshold kept", v, 3);
        chk("R8 empty below", below_mark, 1);
        wr(8'h1C, 16'h0011);
        chk("R9 after flush", pop_data, 8'h11);
        wr(8'h1C, 16'h0012);
        chk("R8 level2 below", below_mark, 1);
        wr(8'h1C, 16'h0013);
        chk("R8 level3 not below", below_mark, 0);
        do_pop();
        chk("R8 level2 again", below_mark, 1);
        wr(8'h28, 16'h0000);
        chk("R8 thr zero", below_mark, 0);
    endtask

    task automatic t_other_addr();
        int v;
        wr(8'h24, 16'hFFFF);
        chk("R10 level unchanged", level, 2);
        rd_thr(v);
        chk("R10 threshold unchanged", v, 0);
        reg_addr = 8'h1C;
        #1 chk("R10 other read", reg_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_overflow();
        t_underflow();
        t_simul();
        t_thresh();
        t_flush_mark();
        t_other_addr();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule